// File: doc/BRIEF.md
# Result SRAM address generator

This block forms the 22-bit address and the active-low strobes that a search device places on an external result SRAM. Every SRAM cycle that the device can start comes through here: a search that this device won, a learn that writes a new entry, or a host access aimed at the external SRAM. The address is built from three parts. The top bits are page bits taken from the command. The middle bits are the ID of the device that drives the bus. The low 14 bits are an index, and its source depends on the operation.

A search that hits stores its match index in one of a small set of result registers. A later host access can then address the SRAM through one of those registers instead of giving a full index. When a device is not the one selected, it holds its outputs at a fixed idle pattern and lowers a drive flag, so several devices can share the bus. A 3-bit programmable delay sets when the address and strobes appear. The same delay applies to every kind of operation.

Top module: `sram_addr_gen`

## Requirements
- R1: A driven address is {page_i, my_id_i, index}: bits [21:19] are the page, bits [18:14] are the device ID, and bits [13:0] are the index.
- R2: A search (op_kind_i = 0) drives a read cycle (WE high) with index = match_idx_i only when win_i is 1. With win_i = 0 no cycle is issued.
- R3: A search with win_i = 1 stores match_idx_i in result register res_sel_i. A host access sampled on the very next cycle already sees the new value.
- R4: A learn (op_kind_i = 1) drives a write cycle (WE low) with index = nfa_i when win_i is 1. With win_i = 0 no cycle is issued.
- R5: A host read (op_kind_i = 2) drives WE high and a host write (op_kind_i = 3) drives WE low. When use_res_i = 0 the index is pio_idx_i.
- R6: When use_res_i = 1, the host index is {r[13:2], r[1] | pio_idx_i[1], r[0] | pio_idx_i[0]}, where r is result register res_sel_i.
- R7: A host access selects this device when tgt_id_i equals my_id_i, or when tgt_id_i = 5'b11111 and last_dev_i = 1. Any other ID issues no cycle.
- R8: A host access issues an SRAM cycle only when tgt_space_i = 2'b10. The register space 2'b11 and the codes 00 and 01 issue none.
- R9: Address and strobes appear in the cycle that follows the sampling edge plus hit_lat_i further cycles (hit_lat_i from 0 to 7). This holds for every operation kind.
- R10: When not driving, and from reset, sram_addr_o is all ones, CE, WE and ALE are high, and drive_o is 0.
- R11: While driving, CE and ALE are both low for exactly the one cycle of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation sampled this cycle (second command cycle) |
| op_kind_i | input | 2 | 0 search, 1 learn, 2 host read, 3 host write |
| page_i | input | 3 | Command page bits for address [21:19] |
| my_id_i | input | 5 | This device's ID |
| last_dev_i | input | 1 | This device is last in the cascade |
| hit_lat_i | input | 3 | Extra output latency in cycles |
| win_i | input | 1 | This device won the search or learn |
| match_idx_i | input | 14 | Match index of a search |
| res_sel_i | input | 3 | Result register to store into or read from |
| nfa_i | input | 14 | Next-free address for a learn |
| tgt_id_i | input | 5 | Host-targeted device ID |
| tgt_space_i | input | 2 | Host target space, 10 = external SRAM |
| use_res_i | input | 1 | Host index through a result register |
| pio_idx_i | input | 14 | Host-supplied index |
| sram_addr_o | output | 22 | SRAM address |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_ale_no | output | 1 | Address latch enable, active low |
| drive_o | output | 1 | This device drives the SRAM bus |

## Verification
The bench builds the block with its default parameters: a 14-bit index, a 5-bit ID, 3 page bits, a 3-bit latency field and eight result registers. With these defaults every delay from 0 to 7 can be reached, so the bench runs at delays 0, 3 and 7, including back-to-back operations inside the deepest window. Eight registers let a search store into a register that a host access then reads on the very next cycle. Because the ID is 5 bits wide, the all-ones broadcast ID can be tested both with the last-device flag set and with it clear.

// File: rtl/sram_agen_pkg.sv
package sram_agen_pkg;
  typedef enum logic [1:0] {
    OP_SEARCH = 2'd0,
    OP_LEARN  = 2'd1,
    OP_PIO_RD = 2'd2,
    OP_PIO_WR = 2'd3
  } op_e;

  localparam logic [1:0] SPACE_SRAM = 2'b10;
endpackage

// File: rtl/sram_res_regs.sv
module sram_res_regs
  import sram_agen_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int NRES  = 8,
  localparam int SEL_W = $clog2(NRES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  op_e              op_i,
  input  logic [IDX_W-1:0] match_idx_i,
  input  logic [IDX_W-1:0] nfa_i,
  input  logic [IDX_W-1:0] pio_idx_i,
  input  logic             use_res_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] res_q [NRES];
  logic [IDX_W-1:0] res_rd, res_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NRES; k++) res_q[k] <= '0;
    end else if (st_en_i) begin
      res_q[sel_i] <= match_idx_i;
    end
  end

  assign res_rd = res_q[sel_i];

  // low two bits merge the host offset into the stored index
  always_comb begin
    res_idx = res_rd;
    res_idx[1:0] = res_rd[1:0] | pio_idx_i[1:0];
  end

  always_comb begin
    unique case (op_i)
      OP_SEARCH: idx_o = match_idx_i;
      OP_LEARN:  idx_o = nfa_i;
      default:   idx_o = use_res_i ? res_idx : pio_idx_i;
    endcase
  end

  // R3
  res_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_i |=> res_q[$past(sel_i)] == $past(match_idx_i));
endmodule

// File: rtl/sram_dev_match.sv
module sram_dev_match
  import sram_agen_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  op_e             op_i,
  input  logic            win_i,
  input  logic [ID_W-1:0] my_id_i,
  input  logic            last_dev_i,
  input  logic [ID_W-1:0] tgt_id_i,
  input  logic [1:0]      tgt_space_i,
  output logic            go_o,
  output logic            wr_o
);
  logic is_pio, bcast, id_hit, space_ok;

  assign is_pio   = (op_i == OP_PIO_RD) || (op_i == OP_PIO_WR);
  assign bcast    = &tgt_id_i;
  assign id_hit   = (tgt_id_i == my_id_i) || (bcast && last_dev_i);
  assign space_ok = (tgt_space_i == SPACE_SRAM);

  always_comb begin
    go_o = 1'b0;
    if (valid_i) go_o = is_pio ? (id_hit && space_ok) : win_i;
  end

  assign wr_o = (op_i == OP_LEARN) || (op_i == OP_PIO_WR);

  // R8
  space_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pio && tgt_space_i != SPACE_SRAM) |-> !go_o);
  // R7
  bcast_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pio && bcast && !last_dev_i && my_id_i != '1) |-> !go_o);
  // R2
  search_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SEARCH && !win_i) |-> !go_o);
endmodule

// File: rtl/sram_lat_pipe.sv
module sram_lat_pipe #(
  parameter int W     = 24,
  parameter int LAT_W = 3,
  localparam int DEPTH = 1 << LAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  input  logic [LAT_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= '0;
      else         stage_q[k] <= stage_q[k-1];
    end
    // R9
    stage_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_q[k] == $past(stage_q[k-1]));
  end

  assign q_o = stage_q[sel_i];
endmodule

// File: rtl/sram_addr_gen.sv
module sram_addr_gen
  import sram_agen_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int ID_W   = 5,
  parameter int PAGE_W = 3,
  parameter int LAT_W  = 3,
  parameter int NRES   = 8,
  localparam int SEL_W  = $clog2(NRES),
  localparam int ADDR_W = PAGE_W + ID_W + IDX_W,
  localparam int PIPE_W = ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ID_W-1:0]   my_id_i,
  input  logic              last_dev_i,
  input  logic [LAT_W-1:0]  hit_lat_i,
  input  logic              win_i,
  input  logic [IDX_W-1:0]  match_idx_i,
  input  logic [SEL_W-1:0]  res_sel_i,
  input  logic [IDX_W-1:0]  nfa_i,
  input  logic [ID_W-1:0]   tgt_id_i,
  input  logic [1:0]        tgt_space_i,
  input  logic              use_res_i,
  input  logic [IDX_W-1:0]  pio_idx_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_ale_no,
  output logic              drive_o
);
  op_e               op;
  logic [IDX_W-1:0]  idx;
  logic              go, wr, st_en;
  logic [PIPE_W-1:0] pipe_d, pipe_q;
  logic              q_go, q_wr;
  logic [ADDR_W-1:0] q_addr;

  assign op    = op_e'(op_kind_i);
  assign st_en = op_valid_i && (op == OP_SEARCH) && win_i;

  sram_res_regs #(.IDX_W(IDX_W), .NRES(NRES)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_en_i     (st_en),
    .sel_i       (res_sel_i),
    .op_i        (op),
    .match_idx_i (match_idx_i),
    .nfa_i       (nfa_i),
    .pio_idx_i   (pio_idx_i),
    .use_res_i   (use_res_i),
    .idx_o       (idx)
  );

  sram_dev_match #(.ID_W(ID_W)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (op_valid_i),
    .op_i        (op),
    .win_i       (win_i),
    .my_id_i     (my_id_i),
    .last_dev_i  (last_dev_i),
    .tgt_id_i    (tgt_id_i),
    .tgt_space_i (tgt_space_i),
    .go_o        (go),
    .wr_o        (wr)
  );

  assign pipe_d = {go, wr, page_i, my_id_i, idx};

  sram_lat_pipe #(.W(PIPE_W), .LAT_W(LAT_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pipe_d),
    .sel_i  (hit_lat_i),
    .q_o    (pipe_q)
  );

  assign {q_go, q_wr, q_addr} = pipe_q;

  assign drive_o     = q_go;
  assign sram_addr_o = q_go ? q_addr : '1;
  assign sram_ce_no  = !q_go;
  assign sram_ale_no = !q_go;
  assign sram_we_no  = !(q_go && q_wr);

  // R10
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (sram_addr_o == '1 && sram_ce_no && sram_we_no && sram_ale_no));
  // R11
  ce_ale_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no == sram_ale_no);
  // R5
  we_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);
  // R1
  id_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && $stable(my_id_i)) |-> sram_addr_o[IDX_W +: ID_W] == my_id_i);
endmodule

// File: tb/sram_addr_gen_test.sv
`timescale 1ns/1ps
module sram_addr_gen_test;
  localparam int AW = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [2:0]  page = '0;
  logic [4:0]  my_id = 5'd5;
  logic        last_dev = 1'b0;
  logic [2:0]  hit_lat = '0;
  logic        win = 1'b0;
  logic [13:0] match_idx = '0;
  logic [2:0]  res_sel = '0;
  logic [13:0] nfa = '0;
  logic [4:0]  tgt_id = '0;
  logic [1:0]  tgt_space = '0;
  logic        use_res = 1'b0;
  logic [13:0] pio_idx = '0;
  logic [AW-1:0] addr;
  logic        ce_n, we_n, ale_n, drv;

  sram_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .page_i(page), .my_id_i(my_id), .last_dev_i(last_dev), .hit_lat_i(hit_lat),
    .win_i(win), .match_idx_i(match_idx), .res_sel_i(res_sel), .nfa_i(nfa),
    .tgt_id_i(tgt_id), .tgt_space_i(tgt_space), .use_res_i(use_res),
    .pio_idx_i(pio_idx), .sram_addr_o(addr), .sram_ce_no(ce_n),
    .sram_we_no(we_n), .sram_ale_no(ale_n), .drive_o(drv)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          due;
    logic [AW-1:0] a;
    logic        we_n;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [13:0] res_m [8];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the bus against the queue head or the idle pattern
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (q.size() > 0 && q[0].due == cyc) begin
        if (addr !== q[0].a || ce_n !== 1'b0 || ale_n !== 1'b0 ||
            we_n !== q[0].we_n || drv !== 1'b1) begin
          errors++;
          $display("FAIL %s R11 cyc=%0d: addr=%h ce=%b we=%b ale=%b drv=%b expected addr=%h ce=0 we=%b ale=0 drv=1",
                   q[0].tag, cyc, addr, ce_n, we_n, ale_n, drv, q[0].a, q[0].we_n);
        end
        void'(q.pop_front());
      end else if (q.size() > 0 && q[0].due < cyc) begin
        errors++;
        $display("FAIL %s R9 cyc=%0d: item due at %0d not seen", q[0].tag, cyc, q[0].due);
        void'(q.pop_front());
      end else if (addr !== '1 || ce_n !== 1'b1 || we_n !== 1'b1 ||
                   ale_n !== 1'b1 || drv !== 1'b0) begin
        errors++;
        $display("FAIL R10 idle cyc=%0d: addr=%h ce=%b we=%b ale=%b drv=%b expected addr=3fffff ce=1 we=1 ale=1 drv=0",
                 cyc, addr, ce_n, we_n, ale_n, drv);
      end
    end
  end

  task automatic push(input logic [13:0] idx, input logic wr, input string tag);
    exp_t e;
    e.due  = cyc + 1 + int'(hit_lat);
    e.a    = {page, my_id, idx};
    e.we_n = !wr;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic do_search(input logic w, input logic [2:0] sel, input logic [13:0] mi, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'd0; win = w; res_sel = sel; match_idx = mi;
    if (w) begin
      res_m[sel] = mi;
      push(mi, 1'b0, tag);
    end
  endtask

  task automatic do_learn(input logic w, input logic [13:0] nf, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'd1; win = w; nfa = nf;
    if (w) push(nf, 1'b1, tag);
  endtask

  task automatic do_pio(input logic wr, input logic [4:0] tid, input logic [1:0] sp,
                        input logic ur, input logic [2:0] sel, input logic [13:0] pi,
                        input string tag);
    logic [13:0] ix;
    @(negedge clk);
    op_valid = 1'b1; op_kind = wr ? 2'd3 : 2'd2; win = 1'b0;
    tgt_id = tid; tgt_space = sp; use_res = ur; res_sel = sel; pio_idx = pi;
    ix = ur ? {res_m[sel][13:2], res_m[sel][1:0] | pi[1:0]} : pi;
    if (((tid == my_id) || (&tid && last_dev)) && sp == 2'b10) push(ix, wr, tag);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    op_valid = 1'b0; win = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lat(input logic [2:0] l);
    go_idle(10);
    hit_lat = l;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) res_m[k] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (addr !== '1 || ce_n !== 1'b1 || we_n !== 1'b1 || ale_n !== 1'b1 || drv !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: addr=%h ce=%b we=%b ale=%b drv=%b expected addr=3fffff ce=1 we=1 ale=1 drv=0",
               addr, ce_n, we_n, ale_n, drv);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    // delay 0
    set_lat(3'd0);
    page = 3'd3;
    do_search(1'b1, 3'd2, 14'h1234, "R1 R2 R9 search win");
    do_search(1'b0, 3'd4, 14'h0777, "R2 search lost");
    do_learn(1'b1, 14'h0abc, "R4 learn win");
    do_learn(1'b0, 14'h0def, "R4 learn lost");
    do_pio(1'b0, 5'd5, 2'b10, 1'b0, 3'd0, 14'h0111, "R5 host read");
    do_pio(1'b1, 5'd5, 2'b10, 1'b0, 3'd0, 14'h2222, "R5 host write");
    do_pio(1'b0, 5'd6, 2'b10, 1'b0, 3'd0, 14'h0333, "R7 other id");
    do_pio(1'b1, 5'd31, 2'b10, 1'b0, 3'd0, 14'h0444, "R7 bcast not last");
    do_pio(1'b1, 5'd5, 2'b11, 1'b0, 3'd0, 14'h0555, "R8 register space");
    do_pio(1'b0, 5'd5, 2'b01, 1'b0, 3'd0, 14'h0666, "R8 space 01");
    do_pio(1'b0, 5'd5, 2'b10, 1'b1, 3'd2, 14'h0003, "R6 R3 reg read");
    go_idle(4);

    // delay 3, back to back, last device
    set_lat(3'd3);
    page = 3'd5;
    last_dev = 1'b1;
    do_pio(1'b1, 5'd31, 2'b10, 1'b0, 3'd0, 14'h1555, "R7 bcast last");
    do_search(1'b1, 3'd1, 14'h2aa8, "R2 R9 lat3");
    do_learn(1'b1, 14'h3001, "R4 R9 lat3");
    do_pio(1'b0, 5'd5, 2'b10, 1'b1, 3'd1, 14'h0002, "R6 R3 next cycle");
    do_pio(1'b0, 5'd31, 2'b00, 1'b0, 3'd0, 14'h0010, "R8 space 00");
    go_idle(12);

    // delay 7
    set_lat(3'd7);
    page = 3'd7;
    last_dev = 1'b0;
    my_id = 5'd17;
    do_search(1'b1, 3'd5, 14'h3ffc, "R1 R2 R9 lat7");
    do_pio(1'b1, 5'd17, 2'b10, 1'b1, 3'd5, 14'h0001, "R6 R3 lat7");
    do_pio(1'b1, 5'd17, 2'b10, 1'b1, 3'd7, 14'h3ff3, "R6 empty reg");
    do_learn(1'b1, 14'h0000, "R4 lat7");
    do_search(1'b0, 3'd6, 14'h1111, "R2 lat7 lost");
    go_idle(16);

    mon_on = 1'b0;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9: %0d expected items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule